// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This unit applies one of four field operations to a 32-bit operand. It can clear every bit inside a field, set every bit inside a field, or pull a field down to the low end of the word. When pulling a field down it either copies the field's top bit into the upper bits or fills them with zeros. A field is given by two 5-bit positions, `first` and `last`. For clear and set they bound an inclusive range of bit positions. For the two extract operations the operand is shifted left by `first` and then shifted right by `last`.

The two positions come from one of two places. They can be two immediate inputs, or they can be packed into the low ten bits of a second register operand: bits [9:5] hold `first` and bits [4:0] hold `last`. In the packed form, adding 0x21 to the operand moves both positions up by one. A parameter adds a registered output stage with a valid flag. With that stage the result appears one cycle after the request.

Top module: `bfu_top`

## Requirements
- R1: Opcode 2'b00 (clear) returns the operand with bits `first` through `last` inclusive forced to 0 and all other bits unchanged; with operand 0xFFFFFFFF, first=4 and last=19 the result is 0xFFF0000F.
- R2: Opcode 2'b01 (set) returns the operand with bits `first` through `last` inclusive forced to 1 and all other bits unchanged; with operand 0, first=0 and last=15 the result is 0x0000FFFF.
- R3: When `first` equals `last`, clear and set change exactly the one bit at that position.
- R4: When `last` is less than `first`, clear and set return the operand unchanged.
- R5: Opcode 2'b11 (unsigned extract) returns (operand << first) shifted logically right by `last`; 0x00003333 with first=18, last=25 gives 0x00000066, and first=last=31 returns operand bit 0 in result bit 0.
- R6: Opcode 2'b10 (signed extract) returns (operand << first) shifted arithmetically right by `last`; 0x00003333 with first=18, last=25 gives 0xFFFFFFE6.
- R7: With `use_reg`=0 the positions are `imm_first` and `imm_last`. With `use_reg`=1 they are `spec_reg[9:5]` (first) and `spec_reg[4:0]` (last). In that case bits [31:10] of `spec_reg` and both immediates have no effect.
- R8: In register form, adding 0x21 to `spec_reg` moves a single-bit clear or set to the next higher bit.
- R9: With OUT_REG=1, a request with `valid_in`=1 produces its result and `valid_out`=1 one clock later. Requests can be issued on back-to-back cycles. While `valid_in`=0, `result` keeps its last value and `valid_out` is 0.
- R10: After a synchronous reset, `valid_out` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request present this cycle |
| opcode | input | 2 | 00 clear, 01 set, 10 signed extract, 11 unsigned extract |
| use_reg | input | 1 | 1 selects field positions from spec_reg, 0 from immediates |
| src | input | 32 | Operand |
| imm_first | input | 5 | Immediate first position |
| imm_last | input | 5 | Immediate last position |
| spec_reg | input | 32 | Register field specifier, [9:5] first, [4:0] last |
| valid_out | output | 1 | Result valid |
| result | output | 32 | Operation result |

## Verification
Two things can meet in one cycle. The output stage can be handing back the result of one request while the next request, with a different opcode and field source, is captured at the same edge. The bench provokes this by issuing a clear and then a signed extract on back-to-back cycles, and the second request switches to the register form with garbage in the upper bits. At each step it checks that the earlier result is still correct when it is sampled and that the later result does not pick up the earlier request's positions. A run of pseudo-random requests is also compared against a bit-by-bit model that the bench computes itself.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int unsigned BFU_W     = 32;
    localparam int unsigned BFU_POS_W = $clog2(BFU_W);
    localparam int unsigned BFU_SPEC_W = 2 * BFU_POS_W;

    typedef enum logic [1:0] {
        OP_CLR  = 2'b00,
        OP_SET  = 2'b01,
        OP_EXTS = 2'b10,
        OP_EXTZ = 2'b11
    } bfu_op_t;

    typedef struct packed {
        logic [BFU_POS_W-1:0] first;
        logic [BFU_POS_W-1:0] last;
    } bfu_field_t;

    function automatic logic op_is_extract(input bfu_op_t op);
        return (op == OP_EXTS) || (op == OP_EXTZ);
    endfunction

    function automatic logic op_is_signed(input bfu_op_t op);
        return op == OP_EXTS;
    endfunction

    function automatic bfu_field_t unpack_spec(input logic [BFU_SPEC_W-1:0] w);
        bfu_field_t f;
        f.first = w[BFU_SPEC_W-1:BFU_POS_W];
        f.last  = w[BFU_POS_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/bfu_field_sel.sv
module bfu_field_sel
    import bfu_pkg::*;
(
    input  logic                  use_reg,
    input  logic [BFU_POS_W-1:0]  imm_first,
    input  logic [BFU_POS_W-1:0]  imm_last,
    input  logic [BFU_SPEC_W-1:0] spec_low,
    output bfu_field_t            field
);

    bfu_field_t imm_field;
    bfu_field_t reg_field;

    always_comb begin
        imm_field.first = imm_first;
        imm_field.last  = imm_last;
        reg_field       = unpack_spec(spec_low);
        field           = use_reg ? reg_field : imm_field;
    end

endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen
    import bfu_pkg::*;
(
    input  bfu_field_t         field,
    output logic [BFU_W-1:0]   mask
);

    for (genvar i = 0; i < BFU_W; i++) begin : g_bit
        localparam logic [BFU_POS_W-1:0] POS = BFU_POS_W'(i);
        assign mask[i] = (POS >= field.first) && (POS <= field.last);
    end

endmodule

// File: rtl/bfu_shifter.sv
module bfu_shifter
    import bfu_pkg::*;
(
    input  logic [BFU_W-1:0]   src,
    input  bfu_field_t         field,
    input  logic               arith,
    output logic [BFU_W-1:0]   lsh_out,
    output logic [BFU_W-1:0]   ext_out
);

    logic [BFU_W-1:0] lstage [BFU_POS_W+1];
    logic [BFU_W-1:0] rstage [BFU_POS_W+1];
    logic             fill;

    assign lstage[0] = src;

    for (genvar k = 0; k < BFU_POS_W; k++) begin : g_left
        localparam int unsigned AMT = 1 << k;
        assign lstage[k+1] = field.first[k]
                           ? {lstage[k][BFU_W-1-AMT:0], {AMT{1'b0}}}
                           : lstage[k];
    end

    assign lsh_out   = lstage[BFU_POS_W];
    assign fill      = arith & lsh_out[BFU_W-1];
    assign rstage[0] = lsh_out;

    for (genvar k = 0; k < BFU_POS_W; k++) begin : g_right
        localparam int unsigned AMT = 1 << k;
        assign rstage[k+1] = field.last[k]
                           ? {{AMT{fill}}, rstage[k][BFU_W-1:AMT]}
                           : rstage[k];
    end

    assign ext_out = rstage[BFU_POS_W];

endmodule

// File: rtl/bfu_top.sv
module bfu_top
    import bfu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_in,
    input  logic [1:0]           opcode,
    input  logic                 use_reg,
    input  logic [BFU_W-1:0]     src,
    input  logic [BFU_POS_W-1:0] imm_first,
    input  logic [BFU_POS_W-1:0] imm_last,
    input  logic [BFU_W-1:0]     spec_reg,
    output logic                 valid_out,
    output logic [BFU_W-1:0]     result
);

    bfu_op_t          op;
    bfu_field_t       field;
    logic [BFU_W-1:0] mask;
    logic [BFU_W-1:0] lsh_val;
    logic [BFU_W-1:0] ext_val;
    logic [BFU_W-1:0] comb_res;
    logic             spec_unused;

    assign op          = bfu_op_t'(opcode);
    assign spec_unused = ^spec_reg[BFU_W-1:BFU_SPEC_W];

    bfu_field_sel u_sel (
        .use_reg   (use_reg),
        .imm_first (imm_first),
        .imm_last  (imm_last),
        .spec_low  (spec_reg[BFU_SPEC_W-1:0]),
        .field     (field)
    );

    bfu_mask_gen u_mask (
        .field (field),
        .mask  (mask)
    );

    bfu_shifter u_shift (
        .src     (src),
        .field   (field),
        .arith   (op_is_signed(op)),
        .lsh_out (lsh_val),
        .ext_out (ext_val)
    );

    always_comb begin
        unique case (op)
            OP_CLR:  comb_res = src & ~mask;
            OP_SET:  comb_res = src | mask;
            default: comb_res = ext_val;
        endcase
    end

    if (OUT_REG) begin : g_out_reg
        logic             valid_q;
        logic [BFU_W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                res_q   <= '0;
            end else begin
                valid_q <= valid_in;
                if (valid_in) begin
                    res_q <= comb_res;
                end
            end
        end

        assign valid_out = valid_q;
        assign result    = res_q;

        p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
            valid_in |=> valid_out);
        p_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !valid_in |=> ($stable(result) && !valid_out));
        p_reset_r10: assert property (@(posedge clk)
            rst |=> (!valid_out && result == '0));
    end else begin : g_out_comb
        assign valid_out = valid_in;
        assign result    = comb_res;
    end

    // Clear leaves bits outside the field untouched (R1)
    p_clr_outside_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op == OP_CLR) |-> ((comb_res & ~mask) == (src & ~mask)));
    // Set drives every field bit high (R2)
    p_set_inside_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op == OP_SET) |-> ((comb_res & mask) == mask));
    p_one_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && field.first == field.last) |-> ($countones(mask) == 1));
    p_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_in && field.last < field.first) |-> (mask == '0));
    p_extz_top_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op == OP_EXTZ && field.last != '0) |-> !ext_val[BFU_W-1]);
    p_exts_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op == OP_EXTS)
            |-> (ext_val[BFU_W-1] == src[BFU_W-1-int'(field.first)]));
    p_field_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && field.last >= field.first)
            |-> ($countones(mask) == int'(field.last) - int'(field.first) + 1));

    // Left shift places operand bit 0 at position first (R5)
    p_lsh_pos_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_is_extract(op)) |-> (lsh_val[field.first] == src[0]));

endmodule

// File: tb/test_bfu_top.sv
module test_bfu_top;

    logic        clk;
    logic        rst;
    logic        valid_in;
    logic [1:0]  opcode;
    logic        use_reg;
    logic [31:0] src;
    logic [4:0]  imm_first;
    logic [4:0]  imm_last;
    logic [31:0] spec_reg;
    logic        valid_out;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [31:0] rng = 32'h1234_5678;

    bfu_top i_bfu_top (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .opcode    (opcode),
        .use_reg   (use_reg),
        .src       (src),
        .imm_first (imm_first),
        .imm_last  (imm_last),
        .spec_reg  (spec_reg),
        .valid_out (valid_out),
        .result    (result)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] s,
                                         input int a, input int b);
        logic [31:0] r;
        logic [31:0] sh;
        r = s;
        if (op[1] == 1'b0) begin
            for (int i = 0; i < 32; i++)
                if (i >= a && i <= b) r[i] = op[0];
        end else begin
            for (int j = 0; j < 32; j++) sh[j] = (j >= a) ? s[j-a] : 1'b0;
            for (int i = 0; i < 32; i++)
                r[i] = (i + b < 32) ? sh[i+b] : (op[0] ? 1'b0 : sh[31]);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic ur, input logic [31:0] s,
                         input int a, input int b, input logic [31:0] sp);
        valid_in  = 1'b1;
        opcode    = op;
        use_reg   = ur;
        src       = s;
        imm_first = 5'(a);
        imm_last  = 5'(b);
        spec_reg  = sp;
    endtask

    task automatic run_imm(input string tag, input logic [1:0] op, input logic [31:0] s,
                           input int a, input int b, input logic [31:0] exp);
        @(negedge clk);
        drive(op, 1'b0, s, a, b, 32'hFFFF_FC00);
        @(negedge clk);
        valid_in = 1'b0;
        check(tag, result, exp);
        check({tag, " valid"}, {31'd0, valid_out}, 32'd1);
    endtask

    task automatic t_reset;
        check("R10 valid_out", {31'd0, valid_out}, 32'd0);
        check("R10 result", result, 32'd0);
    endtask

    task automatic t_examples;
        run_imm("R1 clr 4..19", 2'b00, 32'hFFFF_FFFF, 4, 19, 32'hFFF0_000F);
        run_imm("R2 set 0..15", 2'b01, 32'h0, 0, 15, 32'h0000_FFFF);
        run_imm("R5 extz 18,25", 2'b11, 32'h0000_3333, 18, 25, 32'h0000_0066);
        run_imm("R6 exts 18,25", 2'b10, 32'h0000_3333, 18, 25, 32'hFFFF_FFE6);
        run_imm("R5 extz 31,31", 2'b11, 32'h0000_0001, 31, 31, 32'h0000_0001);
        run_imm("R5 extz 31,31 b0", 2'b11, 32'hFFFF_FFFE, 31, 31, 32'h0000_0000);
    endtask

    task automatic t_reversed;
        run_imm("R4 clr last<first", 2'b00, 32'hA5A5_5A5A, 20, 3, 32'hA5A5_5A5A);
        run_imm("R4 set last<first", 2'b01, 32'h1234_0000, 9, 8, 32'h1234_0000);
    endtask

    task automatic t_reg_sweep;
        logic [31:0] sp;
        sp = 32'h0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            drive(2'b00, 1'b1, 32'hFFFF_FFFF, 0, 31, sp);
            @(negedge clk);
            check("R3 R8 clr single bit", result, ~(32'h1 << i));
            drive(2'b01, 1'b1, 32'h0, 0, 31, sp);
            @(negedge clk);
            valid_in = 1'b0;
            check("R3 R8 set single bit", result, 32'h1 << i);
            sp = sp + 32'h21;
        end
    endtask

    task automatic t_reg_ignore;
        @(negedge clk);
        drive(2'b00, 1'b1, 32'hFFFF_FFFF, 0, 31, 32'hDEAD_B000 | (32'd4 << 5) | 32'd19);
        @(negedge clk);
        valid_in = 1'b0;
        check("R7 reg field, upper bits and imm ignored", result, 32'hFFF0_000F);
        @(negedge clk);
        drive(2'b11, 1'b1, 32'h0000_3333, 1, 2, 32'h5555_5400 | (32'd18 << 5) | 32'd25);
        @(negedge clk);
        valid_in = 1'b0;
        check("R7 reg extz", result, 32'h0000_0066);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(2'b00, 1'b0, 32'hFFFF_FFFF, 8, 11, 32'h0);
        @(negedge clk);
        check("R9 first of pair", result, 32'hFFFF_F0FF);
        check("R9 first valid", {31'd0, valid_out}, 32'd1);
        drive(2'b10, 1'b1, 32'h0000_3333, 0, 0, 32'hFFFF_FC00 | (32'd18 << 5) | 32'd25);
        @(negedge clk);
        valid_in = 1'b0;
        check("R9 second of pair", result, 32'hFFFF_FFE6);
        src       = 32'h0;
        opcode    = 2'b01;
        imm_first = 5'd0;
        imm_last  = 5'd31;
        use_reg   = 1'b0;
        @(negedge clk);
        check("R9 hold result", result, 32'hFFFF_FFE6);
        check("R9 valid_out low", {31'd0, valid_out}, 32'd0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 200; n++) begin
            logic [31:0] s;
            logic [1:0]  op;
            int a;
            int b;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            s = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            op = rng[1:0];
            a  = int'(rng[8:4]);
            b  = int'(rng[16:12]);
            @(negedge clk);
            drive(op, rng[20], s, a, b, {rng[31:10], 5'(a), 5'(b)});
            @(negedge clk);
            valid_in = 1'b0;
            check("R1 R2 R5 R6 random vs model", result, model(op, s, a, b));
        end
    endtask

    initial begin
        rst       = 1'b1;
        valid_in  = 1'b0;
        opcode    = 2'b00;
        use_reg   = 1'b0;
        src       = 32'h0;
        imm_first = 5'd0;
        imm_last  = 5'd0;
        spec_reg  = 32'h0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_examples;
        t_reversed;
        t_reg_sweep;
        t_reg_ignore;
        t_back_to_back;
        t_random;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        t_reset;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule